// File: doc/BRIEF.md
# Host Parallel Port with DMA

This block gives an external host a window into a processor's memory through a handful of addressed registers. The host drives a 4-bit register select, a one-cycle read or write strobe and a 16-bit data bus. Which register a select reaches depends on a 2-bit map mode held in the control register. Two byte-wide maps each place one byte half of a register at a select, with the byte on data bits 7:0. A 16-bit map places whole registers at even selects. The fourth code is an illegal map in which every select is reserved.

Host accesses that complete the upper half of the address or data register can start a memory transfer on a valid/ready request port. These transfers are loads into the data registers or stores from them. They may also advance the address by 2 or 4, with a carry into an 8-bit extension byte. The data-ready and host-interrupt flags in the control register track these transfers, and an interrupt pin is derived from them.

The request port follows valid/ready rules. Once `mem_valid` rises, the address, direction, size and write data stay stable until a cycle in which `mem_ready` is also high. That cycle completes the transfer. `mem_ready` may be driven high at any time and may depend on `mem_valid`. While a request is pending, `host_wait` is high. The host must then hold off further strobes, because strobes issued during that time are ignored.

Top module: `hpio_port`

## Requirements
- R1: Byte maps. Mode = {ctrl[9], ctrl[1]}; mode 0 is legacy bytes, 1 is extended bytes, 2 is illegal and 3 is 16-bit. In both byte modes:
  - selects 0/1 are address low/high, 2/3 data low/high, 4/5 error mask low/high, 6 error status and 7 control low.
  - In mode 0, selects 8-15 all reach the interrupt register high byte.
  - In mode 1, selects 8/9 are interrupt low/high, 10 is control high, 11 is the extension byte and 12/13 are second data low/high.
  - Byte reads return the byte on bits 7:0 with bits 15:8 zero.
- R2: In mode 3, the full registers are at 0 (address), 2 (data), 4 (error mask), 7 (control), 8 (interrupt) and 12 (second data). Select 6 is error status (low byte) and select 11 is the extension (low byte). A read of any reserved select, including every select in mode 2 and selects 14/15 in mode 1, returns 16'hFFFF.
- R3: A byte-lane write changes only the addressed byte of the target register.
- R4: Control bits are: 0 run, 1 map select, 2 interrupt enable, 3 DMA enable, 4 auto-increment, 5 data-ready, 6 host-interrupt, 8 32-bit DMA, 9 16-bit port. Host writes to control never change bits 5 and 6.
- R5: With DMA enabled, a write to the address high byte or full word starts a load.
  - The load address is {extension, address}, aligned to 2 bytes, or to 4 bytes when ctrl[8] is set.
  - A 16-bit load puts mem_rdata[15:0] in data. A 32-bit load puts mem_rdata[31:16] in data and mem_rdata[15:0] in second data.
  - Data-ready is set when the load completes.
- R6: With DMA enabled, a write to the data high byte or full word starts a store at the current aligned address and clears data-ready when it completes. A 16-bit store drives the data register on mem_wdata[15:0]; a 32-bit store drives {data, second data}.
- R7: A write to the data high byte or full word with auto-increment set advances the address by 2, or by 4 when ctrl[8] is set. A carry out of the 16-bit address increments the extension byte.
- R8: A host read of the data register low byte or full word applies auto-increment. A read of the high byte or full word starts a load when DMA is enabled; for a full word, the load uses the already incremented address.
- R9: A write to the interrupt register high byte or full word sets ctrl[6]. A read of that register's high byte or full word clears ctrl[6]. host_irq is high exactly when ctrl[6] and ctrl[2] are both set.
- R10: Reads of the address register always return bit 0 as 1.
- R11: A control write that takes the run bit from 0 to 1 pulses core_rst for one cycle. The same write sets error status to 0, error mask to 16'hFFFF and control to 16'h0001.
- R12: While a memory request is pending, host_wait is high and the request fields stay stable. Flag and data updates take effect on the handshake cycle.
- R13: After rst_n, control is 0, error mask is 16'hFFFF, error status is 0, and host_wait, host_irq, core_rst and mem_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 4 | Register select |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wr | input | 1 | Write strobe, one cycle |
| host_wdata | input | 16 | Write data (byte modes use bits 7:0) |
| host_rdata | output | 16 | Read data for the selected register, combinational |
| host_wait | output | 1 | Memory request pending; hold off strobes |
| host_irq | output | 1 | Host interrupt pin |
| core_rst | output | 1 | One-cycle reset pulse to the attached core |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted/completed |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_size32 | output | 1 | 1 = 32-bit transfer, 0 = 16-bit |
| mem_addr | output | 24 | Aligned byte address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, sampled on the handshake |

## Verification
The bench targets several corner cases:
- Carry from address 16'hFFFE into the extension byte: a design that drops the carry would leave the extension at its old value.
- A full-word data read in 16-bit mode, which must load from the incremented address: reversing the order would repeat the previous load address.
- Control writes that try to set bits 5 and 6, and the run-bit rising edge that collapses control to 16'h0001: a wrong design would let the host forge flags or would keep the map bits.
- The reserved and illegal selects, which must read all ones.
- Random byte writes in extended mode: a design that wrote both lanes would corrupt the untouched byte.

// File: rtl/hpio_pkg.sv
package hpio_pkg;
  localparam int HW = 16;
  localparam int BW = HW / 2;

  typedef enum logic [3:0] {
    RG_ADDR, RG_EXT, RG_DATA, RG_DATA2, RG_EMASK, RG_ESTAT, RG_CTRL, RG_INTR, RG_NONE
  } reg_e;

  typedef enum logic [1:0] { LN_LO, LN_HI, LN_FULL } lane_e;

  // merge host data into one byte lane or the whole word
  function automatic logic [HW-1:0] put_lane(logic [HW-1:0] old, lane_e ln, logic [HW-1:0] w);
    case (ln)
      LN_LO:   put_lane = {old[HW-1:BW], w[BW-1:0]};
      LN_HI:   put_lane = {w[BW-1:0], old[BW-1:0]};
      default: put_lane = w;
    endcase
  endfunction

  // present one byte lane on the low bits, or the whole word
  function automatic logic [HW-1:0] get_lane(logic [HW-1:0] v, lane_e ln);
    case (ln)
      LN_LO:   get_lane = {{BW{1'b0}}, v[BW-1:0]};
      LN_HI:   get_lane = {{BW{1'b0}}, v[HW-1:BW]};
      default: get_lane = v;
    endcase
  endfunction
endpackage

// File: rtl/hpio_map.sv
module hpio_map
  import hpio_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [3:0] sel,
  output reg_e       rsel,
  output lane_e      lane
);
  always_comb begin
    rsel = RG_NONE;
    lane = LN_FULL;
    if (!mode[1]) begin
      lane = sel[0] ? LN_HI : LN_LO;
      case (sel)
        4'd0, 4'd1: rsel = RG_ADDR;
        4'd2, 4'd3: rsel = RG_DATA;
        4'd4, 4'd5: rsel = RG_EMASK;
        4'd6: begin rsel = RG_ESTAT; lane = LN_LO; end
        4'd7: begin rsel = RG_CTRL;  lane = LN_LO; end
        default: begin
          if (!mode[0]) begin
            rsel = RG_INTR; lane = LN_HI;
          end else begin
            case (sel)
              4'd8:  begin rsel = RG_INTR;  lane = LN_LO; end
              4'd9:  begin rsel = RG_INTR;  lane = LN_HI; end
              4'd10: begin rsel = RG_CTRL;  lane = LN_HI; end
              4'd11: begin rsel = RG_EXT;   lane = LN_LO; end
              4'd12: begin rsel = RG_DATA2; lane = LN_LO; end
              4'd13: begin rsel = RG_DATA2; lane = LN_HI; end
              default: rsel = RG_NONE;
            endcase
          end
        end
      endcase
    end else if (mode[0]) begin
      case (sel)
        4'd0:  rsel = RG_ADDR;
        4'd2:  rsel = RG_DATA;
        4'd4:  rsel = RG_EMASK;
        4'd6:  begin rsel = RG_ESTAT; lane = LN_LO; end
        4'd7:  rsel = RG_CTRL;
        4'd8:  rsel = RG_INTR;
        4'd11: begin rsel = RG_EXT; lane = LN_LO; end
        4'd12: rsel = RG_DATA2;
        default: rsel = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/hpio_dma.sv
module hpio_dma #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_ld,
  input  logic          go_st,
  input  logic          is32,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] st_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic          mem_size32,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          ld_done,
  output logic          st_done
);
  logic          pend, we_q, w32_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; we_q <= 1'b0; w32_q <= 1'b0;
      addr_q <= '0; data_q <= '0;
    end else if (pend) begin
      if (mem_ready) pend <= 1'b0;
    end else if (go_ld || go_st) begin
      pend   <= 1'b1;
      we_q   <= go_st;
      w32_q  <= is32;
      addr_q <= is32 ? {base[AW-1:2], 2'b00} : {base[AW-1:1], 1'b0};
      data_q <= st_data;
    end
  end

  assign mem_valid  = pend;
  assign mem_we     = we_q;
  assign mem_size32 = w32_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = data_q;
  assign busy       = pend;
  assign ld_done    = pend && mem_ready && !we_q;
  assign st_done    = pend && mem_ready && we_q;

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R12
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_ld || go_st) |-> !pend);
  // R8
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_ld |-> !go_st);
endmodule

// File: rtl/hpio_port.sv
module hpio_port
  import hpio_pkg::*;
#(
  parameter int EXT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  host_sel,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        host_wait,
  output logic        host_irq,
  output logic        core_rst,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_we,
  output logic        mem_size32,
  output logic [HW+EXT_W-1:0] mem_addr,
  output logic [2*HW-1:0]     mem_wdata,
  input  logic [2*HW-1:0]     mem_rdata
);
  localparam int MAW = HW + EXT_W;

  logic [HW-1:0]    addr_r, data_r, data2_r, emask_r, ctrl_r, intr_r;
  logic [EXT_W-1:0] ext_r;
  logic [7:0]       estat_r;

  reg_e  rsel;
  lane_e lane;
  logic  busy, ld_done, st_done, go_ld, go_st;
  logic  wr_ev, rd_ev, upper;
  logic  dma_en, auto_inc, w32;

  hpio_map u_map (.mode({ctrl_r[9], ctrl_r[1]}), .sel(host_sel), .rsel(rsel), .lane(lane));

  assign dma_en   = ctrl_r[3];
  assign auto_inc = ctrl_r[4];
  assign w32      = ctrl_r[8];
  assign wr_ev    = host_wr && !busy;
  assign rd_ev    = host_rd && !busy;
  assign upper    = (lane != LN_LO);

  // address after one auto-increment step
  logic [HW:0]      inc_sum;
  logic [HW-1:0]    addr_inc;
  logic [EXT_W-1:0] ext_inc;
  assign inc_sum  = {1'b0, addr_r} + (HW+1)'(w32 ? 4 : 2);
  assign addr_inc = inc_sum[HW-1:0];
  assign ext_inc  = ext_r + EXT_W'(inc_sum[HW]);

  // new register values for a host write
  logic [HW-1:0] addr_wv, data_wv, ctrl_wv;
  always_comb begin
    addr_wv = put_lane(addr_r, lane, host_wdata);
    data_wv = put_lane(data_r, lane, host_wdata);
    ctrl_wv = put_lane(ctrl_r, lane, host_wdata);
    ctrl_wv[6:5] = ctrl_r[6:5];
  end

  logic run_rise;
  assign run_rise = wr_ev && (rsel == RG_CTRL) && !ctrl_r[0] && ctrl_wv[0];

  // DMA start decisions and operands
  logic          ld_by_addr, ld_by_data, inc_on_read;
  logic [MAW-1:0] ld_base;
  assign ld_by_addr  = dma_en && wr_ev && (rsel == RG_ADDR) && upper;
  assign ld_by_data  = dma_en && rd_ev && (rsel == RG_DATA) && upper;
  assign inc_on_read = auto_inc && rd_ev && (rsel == RG_DATA) && (lane != LN_HI);
  assign go_ld = ld_by_addr || ld_by_data;
  assign go_st = dma_en && wr_ev && (rsel == RG_DATA) && upper;

  always_comb begin
    if (ld_by_addr)       ld_base = {ext_r, addr_wv};
    else if (inc_on_read) ld_base = {ext_inc, addr_inc};
    else                  ld_base = {ext_r, addr_r};
  end

  logic [2*HW-1:0] st_word;
  assign st_word = w32 ? {data_wv, data2_r} : {{HW{1'b0}}, data_wv};

  hpio_dma #(.AW(MAW), .DW(2*HW)) u_dma (
    .clk(clk), .rst_n(rst_n), .go_ld(go_ld), .go_st(go_st), .is32(w32),
    .base(ld_base), .st_data(st_word),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_size32(mem_size32), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .ld_done(ld_done), .st_done(st_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_r <= '0; data_r <= '0; data2_r <= '0; intr_r <= '0;
      emask_r <= '1; ctrl_r <= '0; ext_r <= '0; estat_r <= '0;
      core_rst <= 1'b0;
    end else begin
      core_rst <= 1'b0;
      if (ld_done) begin
        if (mem_size32) begin
          data_r  <= mem_rdata[2*HW-1:HW];
          data2_r <= mem_rdata[HW-1:0];
        end else begin
          data_r  <= mem_rdata[HW-1:0];
        end
        ctrl_r[5] <= 1'b1;
      end
      if (st_done) ctrl_r[5] <= 1'b0;
      if (wr_ev) begin
        case (rsel)
          RG_ADDR:  addr_r  <= addr_wv;
          RG_EXT:   ext_r   <= host_wdata[EXT_W-1:0];
          RG_DATA: begin
            data_r <= data_wv;
            if (upper && auto_inc) begin
              addr_r <= addr_inc;
              ext_r  <= ext_inc;
            end
          end
          RG_DATA2: data2_r <= put_lane(data2_r, lane, host_wdata);
          RG_EMASK: emask_r <= put_lane(emask_r, lane, host_wdata);
          RG_ESTAT: estat_r <= host_wdata[7:0];
          RG_CTRL: begin
            if (run_rise) begin
              ctrl_r   <= 16'h0001;
              estat_r  <= '0;
              emask_r  <= '1;
              core_rst <= 1'b1;
            end else begin
              ctrl_r <= ctrl_wv;
            end
          end
          RG_INTR: begin
            intr_r <= put_lane(intr_r, lane, host_wdata);
            if (upper) ctrl_r[6] <= 1'b1;
          end
          default: ;
        endcase
      end
      if (rd_ev) begin
        if (inc_on_read) begin
          addr_r <= addr_inc;
          ext_r  <= ext_inc;
        end
        if (rsel == RG_INTR && upper) ctrl_r[6] <= 1'b0;
      end
    end
  end

  // read mux
  logic [HW-1:0] rd_word;
  always_comb begin
    case (rsel)
      RG_ADDR:  rd_word = addr_r | HW'(1);
      RG_EXT:   rd_word = HW'(ext_r);
      RG_DATA:  rd_word = data_r;
      RG_DATA2: rd_word = data2_r;
      RG_EMASK: rd_word = emask_r;
      RG_ESTAT: rd_word = HW'(estat_r);
      RG_CTRL:  rd_word = ctrl_r;
      RG_INTR:  rd_word = intr_r;
      default:  rd_word = '1;
    endcase
  end
  assign host_rdata = (rsel == RG_NONE) ? '1 : get_lane(rd_word, lane);
  assign host_wait  = busy;
  assign host_irq   = ctrl_r[6] && ctrl_r[2];

  // R4
  ctrl_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && rsel == RG_CTRL && !run_rise) |=> $stable(ctrl_r[6:5]));
  // R5
  load_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> ctrl_r[5]);
  // R6
  store_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |=> !ctrl_r[5]);
  // R11
  core_rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (ctrl_r == 16'h0001 && emask_r == 16'hFFFF && estat_r == 8'h00));
  // R12
  no_strobe_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wait |-> !(host_rd || host_wr));
endmodule

// File: tb/hpio_port_bench.sv
module hpio_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_sel = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_wait, host_irq, core_rst;
  logic        mem_valid, mem_we, mem_size32;
  logic        mem_ready = 1'b0;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  int tests = 0, fails = 0, viol = 0, waitcyc = 0;
  bit done = 0;
  logic [23:0] last_addr;
  logic        last_we, last_sz;
  logic [31:0] last_wd;
  int dly = 0;

  always #2.5 clk = ~clk;

  hpio_port u_hpio_port (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_wait(host_wait),
    .host_irq(host_irq), .core_rst(core_rst), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_size32(mem_size32), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] memf(logic [23:0] a);
    return {~a[15:0], a[15:0] ^ 16'h5A5A};
  endfunction

  function automatic logic [15:0] setb(logic [15:0] old, bit hi, logic [7:0] b);
    return hi ? {b, old[7:0]} : {old[15:8], b};
  endfunction

  // memory responder with random latency
  always @(negedge clk) begin
    if (mem_valid && !host_wait) viol++;
    if (host_wait) waitcyc++;
    if (mem_ready) mem_ready <= 1'b0;
    else if (mem_valid) begin
      if (dly == 0) begin
        mem_ready <= 1'b1;
        mem_rdata <= memf(mem_addr);
        last_addr <= mem_addr; last_we <= mem_we; last_sz <= mem_size32; last_wd <= mem_wdata;
        dly = $urandom % 3;
      end else dly--;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [3:0] s, logic [15:0] d);
    @(negedge clk); host_sel = s; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
    while (host_wait) @(negedge clk);
  endtask

  task automatic hrd(logic [3:0] s, output logic [15:0] q);
    @(negedge clk); host_sel = s; host_rd = 1'b1;
    #1 q = host_rdata;
    @(negedge clk); host_rd = 1'b0;
    while (host_wait) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    logic [15:0] m_emask, m_d2, m_intr;
    logic [7:0]  m_ext;
    logic [23:0] a;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state
    chk("R13 wait", {31'd0, host_wait}, 0);
    chk("R13 irq", {31'd0, host_irq}, 0);
    chk("R13 valid", {31'd0, mem_valid}, 0);
    hrd(4'd7, q); chk("R13 ctrl", q, 16'h0000);
    hrd(4'd4, q); chk("R13 emask lo", q, 16'h00FF);
    hrd(4'd5, q); chk("R13 emask hi", q, 16'h00FF);

    // R11 run rising edge
    hwr(4'd4, 16'h0034); hwr(4'd5, 16'h0012); hwr(4'd6, 16'h005A);
    hrd(4'd5, q); chk("R3 emask hi byte", q, 16'h0012);
    hwr(4'd7, 16'h0001);
    chk("R11 core_rst pulse", {31'd0, core_rst}, 1);
    hrd(4'd4, q); chk("R11 emask lo", q, 16'h00FF);
    hrd(4'd6, q); chk("R11 estat", q, 16'h0000);
    hrd(4'd7, q); chk("R11 ctrl", q, 16'h0001);
    chk("R11 pulse ends", {31'd0, core_rst}, 0);

    // R10 address bit 0
    hwr(4'd0, 16'h0044); hwr(4'd1, 16'h0012);
    hrd(4'd0, q); chk("R10 addr lo", q, 16'h0045);
    hrd(4'd1, q); chk("R1 addr hi", q, 16'h0012);

    // R1 legacy interrupt aliasing, R9 flag
    hwr(4'd8, 16'h00AB);
    hrd(4'd7, q); chk("R9 flag set", q, 16'h0041);
    chk("R9 irq masked", {31'd0, host_irq}, 0);
    hwr(4'd7, 16'h0005);
    hrd(4'd7, q); chk("R4 flag kept", q, 16'h0045);
    chk("R9 irq on", {31'd0, host_irq}, 1);
    hrd(4'd13, q); chk("R1 legacy alias", q, 16'h00AB);
    hrd(4'd7, q); chk("R9 flag cleared", q, 16'h0005);
    chk("R9 irq off", {31'd0, host_irq}, 0);
    hwr(4'd7, 16'h0065);
    hrd(4'd7, q); chk("R4 no forge", q, 16'h0005);

    // extended byte mode
    hwr(4'd7, 16'h0007);
    hwr(4'd11, 16'h003C);
    hrd(4'd11, q); chk("R1 ext", q, 16'h003C);
    hrd(4'd14, q); chk("R2 reserved", q, 16'hFFFF);

    // R3 random byte-lane writes
    m_emask = 16'hFFFF; m_d2 = 16'h0000; m_intr = 16'hAB00; m_ext = 8'h3C;
    hwr(4'd12, 16'h0000); hwr(4'd13, 16'h0000);
    for (int i = 0; i < 48; i++) begin
      logic [7:0] b;
      int t;
      b = 8'($urandom);
      t = $urandom % 6;
      case (t)
        0: begin hwr(4'd4, {8'h00, b}); m_emask = setb(m_emask, 0, b); end
        1: begin hwr(4'd5, {8'h00, b}); m_emask = setb(m_emask, 1, b); end
        2: begin hwr(4'd12, {8'h00, b}); m_d2 = setb(m_d2, 0, b); end
        3: begin hwr(4'd13, {8'h00, b}); m_d2 = setb(m_d2, 1, b); end
        4: begin hwr(4'd8, {8'h00, b}); m_intr = setb(m_intr, 0, b); end
        default: begin hwr(4'd11, {8'h00, b}); m_ext = b; end
      endcase
      case ($urandom % 6)
        0: begin hrd(4'd4, q);  chk("R3 emask lo", q, {8'h00, m_emask[7:0]}); end
        1: begin hrd(4'd5, q);  chk("R3 emask hi", q, {8'h00, m_emask[15:8]}); end
        2: begin hrd(4'd12, q); chk("R3 data2 lo", q, {8'h00, m_d2[7:0]}); end
        3: begin hrd(4'd13, q); chk("R3 data2 hi", q, {8'h00, m_d2[15:8]}); end
        4: begin hrd(4'd8, q);  chk("R3 intr lo", q, {8'h00, m_intr[7:0]}); end
        default: begin hrd(4'd11, q); chk("R3 ext", q, {8'h00, m_ext}); end
      endcase
    end

    // R5 16-bit load from address write
    hwr(4'd7, 16'h001F);
    hwr(4'd11, 16'h003C);
    hwr(4'd0, 16'h0011); hwr(4'd1, 16'h0020);
    chk("R5 load addr", {8'h0, last_addr}, 32'h003C2010);
    chk("R5 load dir", {30'd0, last_we, last_sz}, 0);
    hrd(4'd7, q); chk("R5 ready set", q, 16'h003F);
    a = 24'h3C2010;
    hrd(4'd2, q); chk("R5 data lo", q, {8'h00, memf(a)[7:0]});
    hrd(4'd3, q); chk("R8 data hi old", q, {8'h00, memf(a)[15:8]});
    chk("R8 reload addr", {8'h0, last_addr}, 32'h003C2012);
    hrd(4'd0, q); chk("R8 inc on lo read", q, 16'h0013);

    // R6 16-bit store, R7 increment
    hwr(4'd2, 16'h00CD); hwr(4'd3, 16'h00AB);
    chk("R6 store addr", {8'h0, last_addr}, 32'h003C2012);
    chk("R6 store data", {16'h0, last_wd[15:0]}, 32'h0000ABCD);
    chk("R6 store dir", {31'd0, last_we}, 1);
    hrd(4'd7, q); chk("R6 ready cleared", q, 16'h001F);
    hrd(4'd0, q); chk("R7 inc by 2", q, 16'h0015);

    // R7 carry into extension
    hwr(4'd0, 16'h00FE); hwr(4'd1, 16'h00FF);
    chk("R5 load at top", {8'h0, last_addr}, 32'h003CFFFE);
    hwr(4'd2, 16'h0011); hwr(4'd3, 16'h0022);
    chk("R6 store at top", {8'h0, last_addr}, 32'h003CFFFE);
    hrd(4'd0, q); chk("R7 wrap lo", q, 16'h0001);
    hrd(4'd1, q); chk("R7 wrap hi", q, 16'h0000);
    hrd(4'd11, q); chk("R7 ext carry", q, 16'h003D);

    // 16-bit port with 32-bit DMA
    hwr(4'd10, 16'h0003);
    hrd(4'd7, q); chk("R2 ctrl full", q, 16'h031F);
    hrd(4'd1, q); chk("R2 reserved 16", q, 16'hFFFF);
    hwr(4'd0, 16'h4006);
    chk("R5 load32 addr", {8'h0, last_addr}, 32'h003D4004);
    chk("R5 load32 size", {31'd0, last_sz}, 1);
    a = 24'h3D4004;
    hrd(4'd12, q); chk("R5 data2 low half", q, memf(a)[15:0]);
    hrd(4'd2, q); chk("R5 data high half", q, memf(a)[31:16]);
    chk("R8 full read loads incremented", {8'h0, last_addr}, 32'h003D4008);
    hwr(4'd12, 16'h5555); hwr(4'd2, 16'h7777);
    chk("R6 store32 addr", {8'h0, last_addr}, 32'h003D4008);
    chk("R6 store32 data", last_wd, 32'h77775555);
    hrd(4'd0, q); chk("R7 inc by 4", q, 16'h400F);

    // illegal mode
    hwr(4'd7, 16'h0219);
    hrd(4'd7, q); chk("R2 illegal ctrl", q, 16'hFFFF);
    hrd(4'd0, q); chk("R2 illegal addr", q, 16'hFFFF);

    chk("R12 valid only in wait", viol, 0);
    chk("R12 wait seen", {31'd0, waitcyc > 0}, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule